// File: doc/BRIEF.md
# RS-485 Transceiver Enable Controller

This block sits beside a UART and drives the driver-enable and receiver-enable pins of an external RS-485 line transceiver. Configuration inputs select whether RS-485 operation is on at all, the electrical polarity of each pin, and one of three transfer modes. The modes are full-duplex-style (receive during transmit), software-selected direction, and automatic hardware turnaround. Status from the UART's transmitter (busy, shifter empty) and receiver (frame in progress) decides when each pin is active.

Two single-bit enable registers, one per pin, gate the pins in every mode. The receiver-enable register keeps a written 1 only when the block is built with RS-485 support, so software can detect the feature by writing and reading back. If software clears the receive enable while a frame is arriving, the receive pin stays active until that frame ends, so a character is never cut in half.

Top module: `rs485_xcvr_ctrl`

## Requirements
- R1: After synchronous reset both enable registers read 0 and both pins sit at their inactive level (active-high pin inactive = 0, active-low pin inactive = 1).
- R2: When cfg_en is 0, both pins go to their inactive level one clock later, whatever the mode, enables and status.
- R3: cfg_de_pol and cfg_re_pol choose the pin level: 1 means the pin is driven 1 when active, 0 means it is driven 0 when active.
- R4: Mode 0 (cfg_mode = 2'b00): RE is active whenever its enable is set; DE is active when its enable is set and the transmitter is active (tx_busy = 1 or tx_shift_empty = 0); both may be active together.
- R5: Mode 1 (cfg_mode = 2'b01): DE follows its enable bit; RE is active only when its enable is set and the DE enable is clear.
- R6: Mode 2 (cfg_mode = 2'b10): DE is active while its enable is set and the transmitter is active, staying active until tx_shift_empty returns to 1 after tx_busy drops; RE is active when its enable is set and the transmitter is idle.
- R7: Mode 3 (cfg_mode = 2'b11) behaves exactly as mode 2.
- R8: A pin is never active while its enable register holds 0, apart from the receive hold of R9.
- R9: If the RE enable is cleared while RE is active and rx_in_frame is 1, RE stays active until rx_in_frame falls, then goes inactive one clock later.
- R10: A write strobe loads the enable register from its write data bit on the next clock; with HAS_RS485 = 0 both registers read back 0 after any write.
- R11: Pin activity changes one clock after the inputs that cause it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | RS-485 operation enable |
| cfg_re_pol | input | 1 | RE pin active level (1 = active-high) |
| cfg_de_pol | input | 1 | DE pin active level (1 = active-high) |
| cfg_mode | input | 2 | Transfer mode select |
| de_en_we | input | 1 | Write strobe for DE enable register |
| de_en_wd | input | 1 | Write data for DE enable register |
| re_en_we | input | 1 | Write strobe for RE enable register |
| re_en_wd | input | 1 | Write data for RE enable register |
| de_en_rd | output | 1 | Read-back of DE enable register |
| re_en_rd | output | 1 | Read-back of RE enable register |
| tx_busy | input | 1 | Transmitter has data to send |
| tx_shift_empty | input | 1 | Transmit shifter fully empty, stop bit included |
| rx_in_frame | input | 1 | Receiver is inside a frame |
| de_pin | output | 1 | Driver-enable pin |
| re_pin | output | 1 | Receiver-enable pin |

## Verification
Each mode is driven with an idle transmitter, a busy transmitter, and the tail where tx_busy has dropped but the shifter is still sending; this separates the modes that gate DE on transmit activity from the one that follows software, and catches a turnaround that releases DE before the stop bit. Both enable combinations are applied in mode 1 to show direction exclusivity. The receive hold is tried with the enable cleared inside and outside a frame, which tells a held RE from one that ignores its enable. A second instance built without RS-485 support shows the read-back difference.

// File: rtl/rs485_pkg.sv
package rs485_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        XM_FULL  = 2'b00,
        XM_SW    = 2'b01,
        XM_AUTO  = 2'b10,
        XM_AUTO2 = 2'b11
    } xfer_mode_e;

    typedef struct packed {
        logic de;
        logic re;
    } pin_pair_t;

    function automatic logic drive_level(input logic active, input logic act_high);
        return act_high ? active : ~active;
    endfunction
endpackage

// File: rtl/rs485_en_regs.sv
module rs485_en_regs #(
    parameter bit HAS_RS485 = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic de_we,
    input  logic de_wd,
    input  logic re_we,
    input  logic re_wd,
    output logic de_q,
    output logic re_q
);
    generate
        if (HAS_RS485) begin : g_present
            always_ff @(posedge clk) begin
                if (rst) begin
                    de_q <= 1'b0;
                    re_q <= 1'b0;
                end else begin
                    if (de_we) de_q <= de_wd;
                    if (re_we) re_q <= re_wd;
                end
            end
        end else begin : g_absent
            logic unused_w;
            assign unused_w = &{1'b0, clk, rst, de_we, de_wd, re_we, re_wd};
            assign de_q = 1'b0;
            assign re_q = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/rs485_mode_logic.sv
module rs485_mode_logic
    import rs485_pkg::*;
(
    input  xfer_mode_e mode,
    input  logic       de_en,
    input  logic       tx_active,
    output logic       de_req,
    output logic       re_allow
);
    always_comb begin
        unique case (mode)
            XM_FULL: begin
                de_req   = de_en & tx_active;
                re_allow = 1'b1;
            end
            XM_SW: begin
                de_req   = de_en;
                re_allow = ~de_en;
            end
            default: begin
                de_req   = de_en & tx_active;
                re_allow = ~tx_active;
            end
        endcase
    end
endmodule

// File: rtl/rs485_xcvr_ctrl.sv
module rs485_xcvr_ctrl
    import rs485_pkg::*;
#(
    parameter bit HAS_RS485 = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_re_pol,
    input  logic              cfg_de_pol,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              de_en_we,
    input  logic              de_en_wd,
    input  logic              re_en_we,
    input  logic              re_en_wd,
    output logic              de_en_rd,
    output logic              re_en_rd,
    input  logic              tx_busy,
    input  logic              tx_shift_empty,
    input  logic              rx_in_frame,
    output logic              de_pin,
    output logic              re_pin
);
    logic      de_en_q, re_en_q;
    logic      tx_active;
    logic      de_req, re_allow;
    pin_pair_t act_d, act_q;

    rs485_en_regs #(.HAS_RS485(HAS_RS485)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .de_we (de_en_we),
        .de_wd (de_en_wd),
        .re_we (re_en_we),
        .re_wd (re_en_wd),
        .de_q  (de_en_q),
        .re_q  (re_en_q)
    );

    assign tx_active = tx_busy | ~tx_shift_empty;

    rs485_mode_logic u_mode (
        .mode      (xfer_mode_e'(cfg_mode)),
        .de_en     (de_en_q),
        .tx_active (tx_active),
        .de_req    (de_req),
        .re_allow  (re_allow)
    );

    // RE stays up past a cleared enable while a frame is still arriving.
    always_comb begin
        act_d.de = cfg_en & de_req;
        act_d.re = cfg_en & re_allow & (re_en_q | (act_q.re & rx_in_frame));
    end

    always_ff @(posedge clk) begin
        if (rst) act_q <= '0;
        else     act_q <= act_d;
    end

    assign de_pin   = drive_level(act_q.de, cfg_de_pol);
    assign re_pin   = drive_level(act_q.re, cfg_re_pol);
    assign de_en_rd = de_en_q;
    assign re_en_rd = re_en_q;
endmodule

// File: rtl/rs485_xcvr_ctrl_chk.sv
module rs485_xcvr_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_en,
    input logic [1:0] cfg_mode,
    input logic       de_en_rd,
    input logic       re_en_rd,
    input logic       tx_busy,
    input logic       tx_shift_empty,
    input logic       rx_in_frame,
    input logic       de_act,
    input logic       re_act
);
    a_r2_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> (!de_act && !re_act));

    a_r8_de_needs_enable: assert property (@(posedge clk) disable iff (rst)
        !de_en_rd |=> !de_act);

    a_r5_sw_mode_exclusive: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_mode == 2'b01 && de_en_rd) |=> !re_act);

    a_r6_auto_turnaround: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_mode[1] && (tx_busy || !tx_shift_empty)) |=> !re_act);

    a_r9_hold_in_frame: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_mode == 2'b00 && re_act && rx_in_frame) |=> re_act);

    a_r7_auto_idle_re: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && cfg_mode == 2'b11 && re_en_rd && tx_shift_empty && !tx_busy) |=> re_act);
endmodule

bind rs485_xcvr_ctrl rs485_xcvr_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_en         (cfg_en),
    .cfg_mode       (cfg_mode),
    .de_en_rd       (de_en_rd),
    .re_en_rd       (re_en_rd),
    .tx_busy        (tx_busy),
    .tx_shift_empty (tx_shift_empty),
    .rx_in_frame    (rx_in_frame),
    .de_act         (act_q.de),
    .re_act         (act_q.re)
);

// File: tb/rs485_xcvr_ctrl_tb.sv
module rs485_xcvr_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0, cfg_re_pol = 1'b1, cfg_de_pol = 1'b1;
    logic [1:0] cfg_mode = 2'b00;
    logic       de_en_we = 1'b0, de_en_wd = 1'b0, re_en_we = 1'b0, re_en_wd = 1'b0;
    logic       tx_busy = 1'b0, tx_shift_empty = 1'b1, rx_in_frame = 1'b0;
    logic       de_en_rd, re_en_rd, de_pin, re_pin;
    logic       b_de_en_rd, b_re_en_rd, b_de_pin, b_re_pin;
    int         n_checks = 0, n_fail = 0;

    always #4 clk = ~clk;

    rs485_xcvr_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_re_pol(cfg_re_pol), .cfg_de_pol(cfg_de_pol),
        .cfg_mode(cfg_mode), .de_en_we(de_en_we), .de_en_wd(de_en_wd), .re_en_we(re_en_we),
        .re_en_wd(re_en_wd), .de_en_rd(de_en_rd), .re_en_rd(re_en_rd), .tx_busy(tx_busy),
        .tx_shift_empty(tx_shift_empty), .rx_in_frame(rx_in_frame), .de_pin(de_pin), .re_pin(re_pin)
    );

    rs485_xcvr_ctrl #(.HAS_RS485(1'b0)) u_bare (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_re_pol(cfg_re_pol), .cfg_de_pol(cfg_de_pol),
        .cfg_mode(cfg_mode), .de_en_we(de_en_we), .de_en_wd(de_en_wd), .re_en_we(re_en_we),
        .re_en_wd(re_en_wd), .de_en_rd(b_de_en_rd), .re_en_rd(b_re_en_rd), .tx_busy(tx_busy),
        .tx_shift_empty(tx_shift_empty), .rx_in_frame(rx_in_frame), .de_pin(b_de_pin), .re_pin(b_re_pin)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // advance one clock; inputs set before the call are sampled on its edge
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_en(input logic de, input logic re);
        de_en_we = 1'b1; de_en_wd = de;
        re_en_we = 1'b1; re_en_wd = re;
        tick();
        de_en_we = 1'b0; re_en_we = 1'b0;
    endtask

    task automatic set_tx(input logic busy, input logic empty);
        tx_busy = busy; tx_shift_empty = empty;
    endtask

    task automatic t_reset();
        chk("R1 de_en_rd", de_en_rd, 1'b0);
        chk("R1 re_en_rd", re_en_rd, 1'b0);
        chk("R1 de_pin", de_pin, 1'b0);
        chk("R1 re_pin", re_pin, 1'b0);
    endtask

    task automatic t_mode0();
        cfg_en = 1'b1; cfg_mode = 2'b00; set_tx(1'b0, 1'b1);
        wr_en(1'b1, 1'b1);
        chk("R10 de_en_rd", de_en_rd, 1'b1);
        chk("R10 re_en_rd", re_en_rd, 1'b1);
        tick();
        chk("R4 idle de", de_pin, 1'b0);
        chk("R4 idle re", re_pin, 1'b1);
        set_tx(1'b1, 1'b0);
        chk("R11 de before edge", de_pin, 1'b0);
        tick();
        chk("R4 busy de", de_pin, 1'b1);
        chk("R4 busy re", re_pin, 1'b1);
        cfg_de_pol = 1'b0; cfg_re_pol = 1'b0;
        tick();
        chk("R3 de low-active", de_pin, 1'b0);
        chk("R3 re low-active", re_pin, 1'b0);
        cfg_de_pol = 1'b1; cfg_re_pol = 1'b1;
        wr_en(1'b0, 1'b1);
        tick();
        chk("R8 de no enable", de_pin, 1'b0);
        set_tx(1'b0, 1'b1);
    endtask

    task automatic t_mode1();
        cfg_mode = 2'b01;
        wr_en(1'b1, 1'b1);
        tick();
        chk("R5 both en de", de_pin, 1'b1);
        chk("R5 both en re", re_pin, 1'b0);
        wr_en(1'b0, 1'b1);
        tick();
        chk("R5 re only de", de_pin, 1'b0);
        chk("R5 re only re", re_pin, 1'b1);
    endtask

    task automatic t_mode2(input logic [1:0] m, input string req);
        cfg_mode = m;
        wr_en(1'b1, 1'b1);
        set_tx(1'b0, 1'b1);
        tick();
        chk({req, " idle de"}, de_pin, 1'b0);
        chk({req, " idle re"}, re_pin, 1'b1);
        set_tx(1'b1, 1'b0);
        tick();
        chk({req, " busy de"}, de_pin, 1'b1);
        chk({req, " busy re"}, re_pin, 1'b0);
        set_tx(1'b0, 1'b0);
        tick(); tick();
        chk({req, " tail de"}, de_pin, 1'b1);
        chk({req, " tail re"}, re_pin, 1'b0);
        set_tx(1'b0, 1'b1);
        tick();
        chk({req, " done de"}, de_pin, 1'b0);
        chk({req, " done re"}, re_pin, 1'b1);
    endtask

    task automatic t_hold();
        cfg_mode = 2'b00; set_tx(1'b0, 1'b1);
        wr_en(1'b0, 1'b1);
        rx_in_frame = 1'b1;
        tick();
        wr_en(1'b0, 1'b0);
        chk("R9 re_en_rd cleared", re_en_rd, 1'b0);
        tick(); tick(); tick();
        chk("R9 re held in frame", re_pin, 1'b1);
        rx_in_frame = 1'b0;
        tick();
        chk("R9 re released", re_pin, 1'b0);
        wr_en(1'b0, 1'b1);
        tick();
        wr_en(1'b0, 1'b0);
        tick();
        chk("R8 re drops outside frame", re_pin, 1'b0);
    endtask

    task automatic t_disable();
        cfg_mode = 2'b00;
        wr_en(1'b1, 1'b1);
        set_tx(1'b1, 1'b0);
        tick();
        chk("R2 pre de", de_pin, 1'b1);
        cfg_en = 1'b0;
        tick();
        chk("R2 off de", de_pin, 1'b0);
        chk("R2 off re", re_pin, 1'b0);
        set_tx(1'b0, 1'b1);
    endtask

    task automatic t_bare();
        cfg_en = 1'b1; cfg_mode = 2'b00;
        wr_en(1'b1, 1'b1);
        chk("R10 bare re_en_rd", b_re_en_rd, 1'b0);
        chk("R10 bare de_en_rd", b_de_en_rd, 1'b0);
        chk("R10 full re_en_rd", re_en_rd, 1'b1);
        tick();
        chk("R8 bare re_pin", b_re_pin, 1'b0);
    endtask

    initial begin
        fork
            begin
                tick(); tick();
                rst = 1'b0;
                tick();
                t_reset();
                t_mode0();
                t_mode1();
                t_mode2(2'b10, "R6");
                t_mode2(2'b11, "R7");
                t_hold();
                t_disable();
                t_bare();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule